// File: doc/BRIEF.md
# Two-Digit Minute Counter with Serial Seven-Segment Output

This block keeps a decimal minute count between 00 and 99 as two BCD digits. A prescaler divides the system clock down to one step per minute. The number of clock cycles in a minute is fixed when the block is built. A push-button also steps the count by hand, so the user can set the displayed minute. Both sources feed one increment path and follow the same wrap rule. After 99 the count returns to 00 and keeps running.

The two digits are converted to seven-segment patterns and sent out as one 16-bit serial frame. The frame goes to two cascaded serial-in shift registers that drive the digit displays. It uses three wires: data, shift clock and latch strobe. A new frame starts whenever the count changes. A change that arrives while a frame is on the wire waits until that frame has finished, so no frame is ever cut short.

Top module: `minute_display_top`

## Requirements
- R1: Each digit is kept in BCD and never goes above 9, so the value stays within 00..99.
- R2: When the value is 99, the next step gives 00, and counting then continues as normal.
- R3: A timed step happens every TICK_CYCLES clock cycles. The first one happens on the TICK_CYCLES-th rising edge after reset is released.
- R4: The button input is synchronised by two flops. A new button level is accepted only after the synchronised level has held for DEB_CYCLES cycles in a row. Each accepted press gives exactly one step, a release gives none, and a shorter pulse or bounce gives none.
- R5: A timed step and an accepted press in the same cycle together advance the value by one only.
- R6: A frame is 16 bits, with the tens byte first and each byte MSB first. The receiver takes each bit on the rising edge of ser_clk. ser_clk is low for HALF_DIV cycles and then high for HALF_DIV cycles per bit.
- R7: After the 16th bit, ser_latch is high for 2*HALF_DIV cycles while ser_clk stays low.
- R8: Segment byte layout is bit0..bit6 = segments a..g, active high, and bit7 = decimal point, which is always 0. The digit codes are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F (hex).
- R9: Every change of the value starts a frame that carries the latest value. A change during a frame is held and sent after that frame ends. After reset, one frame showing 00 is sent. While reset is held, all three serial outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| set_btn | input | 1 | Raw push-button level that steps the minute by hand |
| ser_data | output | 1 | Serial segment data to the first shift register |
| ser_clk | output | 1 | Shift clock; the receiver samples data on its rising edge |
| ser_latch | output | 1 | Strobe that copies the shifted bits to the display outputs |

## Verification
A corrupted digit or a wrong carry appears in the next latched frame. That frame ends about 2*HALF_DIV*17 cycles after the change, and the receiver word then differs from the value computed from ticks and presses. A prescaler that is off by one cycle moves the start of the first timed frame away from the cycle the bench predicts. A broken debounce or merge rule leaves the latched value one step off from the model for the rest of the run. A fault in the framing state shows as a bit count other than 16 at the latch edge, or as a latch pulse of the wrong length.

// File: rtl/minute_disp_pkg.sv
package minute_disp_pkg;

    localparam int unsigned NUM_DIGITS = 2;
    localparam int unsigned SEG_BITS   = 8;
    localparam int unsigned FRAME_BITS = NUM_DIGITS * SEG_BITS;

    typedef logic [3:0] bcd_t;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SHIFT = 2'd1,
        TX_LATCH = 2'd2
    } tx_state_e;

    // bit0..bit6 = a..g, bit7 = decimal point (kept off)
    function automatic logic [SEG_BITS-1:0] seg_of(input bcd_t digit);
        logic [SEG_BITS-1:0] pat;
        case (digit)
            4'd0:    pat = 8'h3F;
            4'd1:    pat = 8'h06;
            4'd2:    pat = 8'h5B;
            4'd3:    pat = 8'h4F;
            4'd4:    pat = 8'h66;
            4'd5:    pat = 8'h6D;
            4'd6:    pat = 8'h7D;
            4'd7:    pat = 8'h07;
            4'd8:    pat = 8'h7F;
            4'd9:    pat = 8'h6F;
            default: pat = 8'h00;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/md_prescaler.sv
module md_prescaler #(
    parameter int unsigned TICK_CYCLES = 32'd3000000000,
    localparam int unsigned CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == LAST);
        if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/md_debounce.sv
module md_debounce #(
    parameter int unsigned DEB_CYCLES = 500000,
    localparam int unsigned CW = $clog2(DEB_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic press
);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          level;
        logic [CW-1:0] cnt;
        logic          pulse;
    } deb_st_t;

    deb_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.s1    = btn_raw;
        st_d.s2    = st_q.s1;
        st_d.pulse = 1'b0;
        if (st_q.s2 != st_q.level) begin
            if (st_q.cnt == LAST) begin
                st_d.level = st_q.s2;
                st_d.cnt   = '0;
                st_d.pulse = st_q.s2;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign press = st_q.pulse;

endmodule

// File: rtl/md_bcd_counter.sv
module md_bcd_counter
    import minute_disp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic press,
    output logic stepped,
    output bcd_t tens,
    output bcd_t units
);
    typedef struct packed {
        bcd_t tens;
        bcd_t units;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        stepped = tick | press;
        if (stepped) begin
            if (st_q.units == 4'd9) begin
                st_d.units = 4'd0;
                st_d.tens  = (st_q.tens == 4'd9) ? 4'd0 : st_q.tens + 4'd1;
            end else begin
                st_d.units = st_q.units + 4'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tens  = st_q.tens;
    assign units = st_q.units;

endmodule

// File: rtl/md_serial_tx.sv
module md_serial_tx
    import minute_disp_pkg::*;
#(
    parameter int unsigned HALF_DIV = 4,
    localparam int unsigned DIV_W = $clog2(2 * HALF_DIV),
    localparam int unsigned BIT_W = $clog2(FRAME_BITS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req,
    input  logic [FRAME_BITS-1:0] frame,
    output logic                  sdata,
    output logic                  sclk,
    output logic                  slatch
);
    localparam logic [DIV_W-1:0] HALF_LAST  = DIV_W'(HALF_DIV - 1);
    localparam logic [DIV_W-1:0] LATCH_LAST = DIV_W'(2 * HALF_DIV - 1);
    localparam logic [BIT_W-1:0] BIT_LAST   = BIT_W'(FRAME_BITS - 1);

    typedef struct packed {
        tx_state_e             state;
        logic                  pend;
        logic                  phase;
        logic [DIV_W-1:0]      div;
        logic [BIT_W-1:0]      bitn;
        logic [FRAME_BITS-1:0] sh;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic   load;

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        case (st_q.state)
            TX_IDLE: begin
                if (st_q.pend) begin
                    load       = 1'b1;
                    st_d.state = TX_SHIFT;
                    st_d.sh    = frame;
                    st_d.div   = '0;
                    st_d.phase = 1'b0;
                    st_d.bitn  = '0;
                end
            end
            TX_SHIFT: begin
                if (st_q.div == HALF_LAST) begin
                    st_d.div = '0;
                    if (!st_q.phase) begin
                        st_d.phase = 1'b1;
                    end else begin
                        st_d.phase = 1'b0;
                        st_d.sh    = {st_q.sh[FRAME_BITS-2:0], 1'b0};
                        if (st_q.bitn == BIT_LAST) begin
                            st_d.state = TX_LATCH;
                        end else begin
                            st_d.bitn = st_q.bitn + 1'b1;
                        end
                    end
                end else begin
                    st_d.div = st_q.div + 1'b1;
                end
            end
            TX_LATCH: begin
                if (st_q.div == LATCH_LAST) begin
                    st_d.div   = '0;
                    st_d.state = TX_IDLE;
                end else begin
                    st_d.div = st_q.div + 1'b1;
                end
            end
            default: st_d.state = TX_IDLE;
        endcase
        st_d.pend = (st_q.pend & ~load) | req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.pend <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdata  = (st_q.state == TX_SHIFT) & st_q.sh[FRAME_BITS-1];
    assign sclk   = (st_q.state == TX_SHIFT) & st_q.phase;
    assign slatch = (st_q.state == TX_LATCH);

endmodule

// File: rtl/minute_display_top.sv
module minute_display_top
    import minute_disp_pkg::*;
#(
    parameter int unsigned TICK_CYCLES = 32'd3000000000,
    parameter int unsigned DEB_CYCLES  = 500000,
    parameter int unsigned HALF_DIV    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic set_btn,
    output logic ser_data,
    output logic ser_clk,
    output logic ser_latch
);
    logic                  tick;
    logic                  press;
    logic                  cnt_step;
    bcd_t                  tens_q;
    bcd_t                  units_q;
    logic [FRAME_BITS-1:0] frame_word;

    md_prescaler #(.TICK_CYCLES(TICK_CYCLES)) i_prescaler (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    md_debounce #(.DEB_CYCLES(DEB_CYCLES)) i_debounce (
        .clk     (clk),
        .rst     (rst),
        .btn_raw (set_btn),
        .press   (press)
    );

    md_bcd_counter i_counter (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .press   (press),
        .stepped (cnt_step),
        .tens    (tens_q),
        .units   (units_q)
    );

    assign frame_word = {seg_of(tens_q), seg_of(units_q)};

    md_serial_tx #(.HALF_DIV(HALF_DIV)) i_tx (
        .clk    (clk),
        .rst    (rst),
        .req    (cnt_step),
        .frame  (frame_word),
        .sdata  (ser_data),
        .sclk   (ser_clk),
        .slatch (ser_latch)
    );

endmodule

// File: rtl/md_checker.sv
module md_checker (
    input logic       clk,
    input logic       rst,
    input logic       step,
    input logic [3:0] tens,
    input logic [3:0] units,
    input logic       ser_clk,
    input logic       ser_data,
    input logic       ser_latch
);
    logic [7:0] val;
    assign val = 8'(tens) * 8'd10 + 8'(units);

    AST_BCD_RANGE: assert property (@(posedge clk) disable iff (rst)
        (tens <= 4'd9) && (units <= 4'd9)); // R1
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (step && tens == 4'd9 && units == 4'd9) |=> (tens == 4'd0 && units == 4'd0)); // R2
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> (val == (($past(val) == 8'd99) ? 8'd0 : $past(val) + 8'd1))); // R5
    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(val)); // R3
    AST_LATCH_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        ser_latch |-> !ser_clk); // R7
    AST_DATA_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data)); // R6

endmodule

bind minute_display_top md_checker i_md_checker (
    .clk       (clk),
    .rst       (rst),
    .step      (cnt_step),
    .tens      (tens_q),
    .units     (units_q),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .ser_latch (ser_latch)
);

// File: tb/test_minute_display_top.sv
module test_minute_display_top;
    localparam int TICK = 400;
    localparam int DEB  = 8;
    localparam int HALF = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic set_btn = 1'b0;
    logic ser_data, ser_clk, ser_latch;

    always #2 clk = ~clk;

    minute_display_top #(.TICK_CYCLES(TICK), .DEB_CYCLES(DEB), .HALF_DIV(HALF)) i_minute_display_top (
        .clk (clk), .rst (rst), .set_btn (set_btn),
        .ser_data (ser_data), .ser_clk (ser_clk), .ser_latch (ser_latch)
    );

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int presses = 0;
    int merges = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] seg(input int d);
        case (d)
            0: return 8'h3F; 1: return 8'h06; 2: return 8'h5B; 3: return 8'h4F;
            4: return 8'h66; 5: return 8'h6D; 6: return 8'h7D; 7: return 8'h07;
            8: return 8'h7F; default: return 8'h6F;
        endcase
    endfunction

    function automatic logic [15:0] enc(input int v);
        return {seg(v / 10), seg(v % 10)};
    endfunction

    function automatic int exp_val();
        return (cyc / TICK + presses - merges) % 100;
    endfunction

    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    // serial receiver model, sampled away from the active edge
    logic [15:0] rx = '0;
    logic [15:0] last_word = '0;
    int nbits = 0, frames = 0, latch_len = 0, hi_len = 0, start_cyc = -1;
    logic p_sclk = 1'b0, p_latch = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (ser_clk && !p_sclk) begin
                if (nbits == 0) start_cyc = cyc;
                rx = {rx[14:0], ser_data};
                nbits++;
                hi_len = 0;
            end
            if (ser_clk) hi_len++;
            if (!ser_clk && p_sclk) check(hi_len == HALF, "R6 clk high width", hi_len, HALF);
            if (ser_latch && !p_latch) begin
                frames++;
                check(nbits == 16, "R6 bits per frame", nbits, 16);
                last_word = rx;
                nbits = 0;
                latch_len = 0;
            end
            if (ser_latch) latch_len++;
            if (!ser_latch && p_latch) check(latch_len == 2 * HALF, "R7 latch width", latch_len, 2 * HALF);
            p_sclk = ser_clk;
            p_latch = ser_latch;
        end
    end

    task automatic wait_mod(input int m);
        do @(negedge clk); while (cyc % TICK != m);
    endtask

    task automatic press(input int hold);
        set_btn = 1'b1;
        repeat (hold) @(negedge clk);
        set_btn = 1'b0;
        presses++;
    endtask

    initial begin
        int prev_exp;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check({ser_data, ser_clk, ser_latch} == 3'b000, "R9 outputs low in reset",
              {ser_data, ser_clk, ser_latch}, 0);
        rst = 1'b0;

        do @(negedge clk); while (cyc != TICK - 2);
        check(frames == 1, "R9 one frame after reset", frames, 1);
        check(last_word == 16'h3F3F, "R9 R8 reset frame shows 00", last_word, 16'h3F3F);

        do @(negedge clk); while (cyc != TICK + 100);
        check(start_cyc == TICK + 1 + HALF, "R3 first timed frame start", start_cyc, TICK + 1 + HALF);
        check(last_word == enc(1), "R3 R8 value after first tick", last_word, enc(1));

        prev_exp = 1;
        for (int p = 0; p < 70; p++) begin
            int opt;
            int f0;
            int ev;
            opt = int'($urandom % 4);
            f0 = frames;
            case (opt)
                1: begin // bouncy press, one step (R4)
                    wait_mod(40);
                    set_btn = 1'b1; repeat (2) @(negedge clk);
                    set_btn = 1'b0; repeat (2) @(negedge clk);
                    press(20);
                end
                2: begin // press lands while the tick frame is on the wire (R9)
                    wait_mod(5);
                    press(20);
                end
                3: begin // glitch shorter than the debounce window (R4)
                    wait_mod(40);
                    set_btn = 1'b1;
                    repeat ($urandom_range(1, DEB - 2)) @(negedge clk);
                    set_btn = 1'b0;
                end
                default: ;
            endcase
            wait_mod(350);
            ev = exp_val();
            check(last_word == enc(ev), $sformatf("R1 R4 R8 R9 value opt%0d", opt), last_word, enc(ev));
            check(frames > f0, "R9 frame after change", frames - f0, 1);
            if (ev < prev_exp) check(last_word == enc(ev), "R2 wrap past 99", last_word, enc(ev));
            prev_exp = ev;
        end

        // sweep press timing across a tick: exactly one press coincides (R5)
        for (int k = 0; k <= 30; k++) begin
            wait_mod((TICK - k) % TICK);
            press(20);
        end
        merges = 1;
        wait_mod(350);
        check(last_word == enc(exp_val()), "R5 tick and press merge once", last_word, enc(exp_val()));
        check(frames > 0, "R2 counting continues", frames, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule